// File: doc/BRIEF.md
# Interval Clock with Overflow Interrupt

This block is a laboratory timing clock that sits beside a host processor. It counts time marks taken from one of several asynchronous tick sources, a 1 kHz source in the usual setup, in a 12-bit counter with a separate overflow bit. The overflow bit stays set while the counter keeps running, so it works as a 13th bit. The host can use the clock in two ways. In interrogation mode it reads the time word whenever it needs to. In interrupt mode it presets the counter so that the wrap from all ones to zero marks the end of the wanted interval. The interrupt request is then raised if it has been enabled.

Every tick source passes through a two-flop synchroniser and an edge detector. A select input picks the source, so software chooses the time base. The host uses level strobes for read, write and clear. A transfer lasts as long as a strobe is held, and the counter is frozen for that whole time. A tick that arrives during the transfer is kept as pending. All pending ticks are added on the first cycle after the strobes drop, so a read taken on the fly loses no count. A small state machine with the states STOP, RUN and XFER controls the counter:

- STOP to RUN when tick enable is set.
- RUN to STOP when tick enable is cleared.
- STOP or RUN to XFER when any transfer strobe rises.
- XFER back to RUN or STOP, depending on tick enable, when all strobes are low again. This is the cycle in which pending ticks are applied.

Top module: `interval_clock`

## Requirements
- R1: After reset the counter is 0, the overflow bit is 0, both enables are off, the state is STOP and `irq` is low.
- R2: While tick enable is set, each rising edge on the selected tick source adds exactly one to the counter, however long the source stays high. The counter changes on the third clock edge after the source is first sampled high.
- R3: `base_sel` picks the source whose index it holds. Edges on every other source have no effect on the count.
- R4: When the counter wraps from 0xFFF to 0x000, the overflow bit is set. Counting continues and the overflow bit stays set until a `bus_ovf_clr` pulse clears it. If a wrap and a clear fall in the same cycle, the bit stays set.
- R5: While tick enable is clear, ticks are dropped and the count holds. Once the enable is set again, counting resumes from the held value, so elapsed time accumulates across stops.
- R6: While `bus_rd`, `bus_wr` or `bus_clr` is high, the counter does not change. A read captures the count and the overflow bit at the first cycle of the transfer and presents them with a one-cycle `rd_valid` pulse one cycle later.
- R7: Ticks that arrive during a transfer, up to three, are held as pending. All of them are added on the first cycle after the strobes drop, so a read that starts on the next cycle already includes them.
- R8: A write loads `wr_data` into the counter at the first cycle of the transfer and leaves the overflow bit unchanged. Ticks from that cycle onwards are applied after the transfer.
- R9: A clear sets the counter to 0. It leaves the overflow bit and both enable bits unchanged.
- R10: `irq` is high exactly while the overflow bit and the interrupt enable are both set.
- R11: When several transfer strobes rise together, clear takes priority over write and write over read. Only the winning operation takes effect, so a losing read produces no `rd_valid`.
- R12: A `bus_ctl_wr` pulse loads `ctl_irq_en` and `ctl_tick_en` into the two enable bits in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | NSRC | Asynchronous time-mark sources |
| base_sel | input | SEL_W | Index of the source that drives the counter |
| bus_rd | input | 1 | Read transfer, held for the bus cycle |
| bus_wr | input | 1 | Write transfer, held for the bus cycle |
| bus_clr | input | 1 | Clear transfer, held for the bus cycle |
| bus_ovf_clr | input | 1 | One-cycle pulse that clears the overflow bit |
| bus_ctl_wr | input | 1 | One-cycle pulse that loads the enable bits |
| ctl_irq_en | input | 1 | Interrupt enable value for `bus_ctl_wr` |
| ctl_tick_en | input | 1 | Tick enable value for `bus_ctl_wr` |
| wr_data | input | CNT_W | Value loaded by a write |
| rd_data | output | CNT_W | Count captured by the last read |
| rd_ovf | output | 1 | Overflow bit captured by the last read |
| rd_valid | output | 1 | One-cycle pulse when read data is presented |
| irq | output | 1 | Interrupt request level |

## Verification
The two collisions that matter are a tick carry that wraps the counter in the same cycle as an overflow-clear pulse, and a tick that lands inside a host transfer. The first is provoked by placing the clear pulse on the exact edge where the synchronised tick is sampled, with the count at 0xFFF and the overflow bit already set. The result is judged by a later read, which must still report overflow. The second is provoked by raising a tick while a read is held and then starting a second read on the cycle right after the first one ends. The first read must exclude the tick and the second must include it, which checks both the hold and the exact cycle of the catch-up.

// File: rtl/icl_pkg.sv
package icl_pkg;

    // Controller states of the interval clock
    typedef enum logic [1:0] {
        S_STOP = 2'd0,   // ticks disabled, no transfer
        S_RUN  = 2'd1,   // ticks enabled, no transfer
        S_XFER = 2'd2    // host transfer in progress, counter frozen
    } clk_state_e;

    // Operation chosen at the first cycle of a transfer
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } xfer_op_e;

endpackage

// File: rtl/icl_tick_sync.sv
// Per-source two-flop synchroniser followed by a rising-edge detector.
module icl_tick_sync #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_src,
    output logic [NSRC-1:0] tick_pls
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // sh[0], sh[1] form the synchroniser; sh[2] is the edge history
        logic [2:0] sh;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh <= {sh[1:0], tick_src[g]};
            end
        end

        assign tick_pls[g] = sh[1] & ~sh[2];
    end

endmodule

// File: rtl/icl_ctrl.sv
// Transfer / run-state controller.
module icl_ctrl
    import icl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic       bus_clr,
    input  logic       tick_en,
    output clk_state_e st_q,
    output logic       any_bus,
    output logic       xfer_start,
    output logic       xfer_end,
    output xfer_op_e   op
);

    clk_state_e st_d;

    assign any_bus = bus_rd | bus_wr | bus_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_STOP: begin
                if (any_bus)      st_d = S_XFER;
                else if (tick_en) st_d = S_RUN;
            end
            S_RUN: begin
                if (any_bus)       st_d = S_XFER;
                else if (!tick_en) st_d = S_STOP;
            end
            S_XFER: begin
                if (!any_bus) st_d = tick_en ? S_RUN : S_STOP;
            end
            default: st_d = S_STOP;
        endcase
    end

    // Output logic: transfer boundaries and the winning operation
    always_comb begin
        xfer_start = 1'b0;
        xfer_end   = 1'b0;
        unique case (st_q)
            S_STOP, S_RUN: xfer_start = any_bus;
            S_XFER:        xfer_end   = !any_bus;
            default: begin
                xfer_start = 1'b0;
                xfer_end   = 1'b0;
            end
        endcase

        // clear beats write, write beats read
        if (!xfer_start)  op = OP_NONE;
        else if (bus_clr) op = OP_CLEAR;
        else if (bus_wr)  op = OP_WRITE;
        else if (bus_rd)  op = OP_READ;
        else              op = OP_NONE;
    end

endmodule

// File: rtl/icl_pend.sv
// Saturating store for ticks that arrive while a transfer freezes the counter.
module icl_pend #(
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              hold,
    input  logic              drop,
    output logic [PEND_W-1:0] pend_q
);

    localparam logic [PEND_W-1:0] PMAX = '1;
    localparam logic [PEND_W-1:0] ONE  = PEND_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (drop) begin
            // the counter is reloaded; only a tick in this very cycle survives
            pend_q <= tick_in ? ONE : '0;
        end else if (hold) begin
            if (tick_in && (pend_q != PMAX)) pend_q <= pend_q + ONE;
        end else begin
            // outside a transfer the pending ticks are folded into the count
            pend_q <= '0;
        end
    end

endmodule

// File: rtl/icl_count.sv
// Time counter with a sticky overflow bit.
module icl_count #(
    parameter int CNT_W  = 12,
    parameter int PEND_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [PEND_W:0]  inc_amt,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    localparam int PAD_W = CNT_W - PEND_W;

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q} + {{PAD_W{1'b0}}, inc_amt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (load_en) begin
            cnt_q <= load_val;
            ovf_q <= ovf_q & ~ovf_clr;
        end else if (hold) begin
            ovf_q <= ovf_q & ~ovf_clr;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
            // a carry in the same cycle as a clear keeps the bit set
            ovf_q <= sum[CNT_W] | (ovf_q & ~ovf_clr);
        end
    end

endmodule

// File: rtl/interval_clock.sv
// Interval clock: selectable tick source, 12-bit counter plus overflow,
// counting held off during host transfers without losing ticks.
module interval_clock
    import icl_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int CNT_W  = 12,
    parameter int PEND_W = 2,
    parameter int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SEL_W-1:0] base_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_clr,
    input  logic             bus_ovf_clr,
    input  logic             bus_ctl_wr,
    input  logic             ctl_irq_en,
    input  logic             ctl_tick_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_ovf,
    output logic             rd_valid,
    output logic             irq
);

    clk_state_e        st_q;
    xfer_op_e          op;
    logic              any_bus;
    logic              xfer_start;
    logic              xfer_end;
    logic [NSRC-1:0]   tick_pls;
    logic              tick_sel;
    logic              tick_acc;
    logic              tick_en_q;
    logic              irq_en_q;
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W:0]   inc_amt;
    logic              load_en;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;

    // Tick front end
    icl_tick_sync #(.NSRC(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_src (tick_src),
        .tick_pls (tick_pls)
    );

    always_comb begin
        tick_sel = 1'b0;
        if (int'(base_sel) < NSRC) tick_sel = tick_pls[base_sel];
    end

    assign tick_acc = tick_sel & tick_en_q;

    // Enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_en_q <= 1'b0;
            irq_en_q  <= 1'b0;
        end else if (bus_ctl_wr) begin
            tick_en_q <= ctl_tick_en;
            irq_en_q  <= ctl_irq_en;
        end
    end

    // Controller
    icl_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_clr    (bus_clr),
        .tick_en    (tick_en_q),
        .st_q       (st_q),
        .any_bus    (any_bus),
        .xfer_start (xfer_start),
        .xfer_end   (xfer_end),
        .op         (op)
    );

    assign load_en  = (op == OP_WRITE) || (op == OP_CLEAR);
    assign load_val = (op == OP_CLEAR) ? '0 : wr_data;

    // Pending ticks during transfers
    icl_pend #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_acc),
        .hold    (any_bus),
        .drop    (load_en),
        .pend_q  (pend_q)
    );

    // pend_q is non-zero outside a transfer only on the catch-up cycle
    assign inc_amt = {1'b0, pend_q} + {{PEND_W{1'b0}}, tick_acc};

    // Counter and overflow
    icl_count #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (any_bus),
        .inc_amt  (inc_amt),
        .load_en  (load_en),
        .load_val (load_val),
        .ovf_clr  (bus_ovf_clr),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q)
    );

    // Read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_ovf   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (op == OP_READ);
            if (op == OP_READ) begin
                rd_data <= cnt_q;
                rd_ovf  <= ovf_q;
            end
        end
    end

    assign irq = ovf_q & irq_en_q;

endmodule

// File: rtl/interval_clock_chk.sv
module interval_clock_chk
    import icl_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PEND_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input clk_state_e        st_q,
    input logic              any_bus,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              ovf_q,
    input logic [PEND_W-1:0] pend_q,
    input logic              tick_en_q,
    input logic              bus_ovf_clr,
    input logic              bus_ctl_wr,
    input logic              rd_valid,
    input logic              irq
);

    AST_XFER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_XFER && any_bus) |=> $stable(cnt_q)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !bus_ovf_clr) |=> ovf_q); // R4

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_q && !any_bus && pend_q == '0) |=> $stable(cnt_q)); // R5

    AST_PEND_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_XFER && !any_bus) |=> (pend_q == '0)); // R7

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_ovf_clr && !bus_ctl_wr) |=> irq); // R10

endmodule

bind interval_clock interval_clock_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_q        (st_q),
    .any_bus     (any_bus),
    .cnt_q       (cnt_q),
    .ovf_q       (ovf_q),
    .pend_q      (pend_q),
    .tick_en_q   (tick_en_q),
    .bus_ovf_clr (bus_ovf_clr),
    .bus_ctl_wr  (bus_ctl_wr),
    .rd_valid    (rd_valid),
    .irq         (irq)
);

// File: tb/interval_clock_test.sv
module interval_clock_test;

    typedef struct {
        logic [11:0] cnt;
        logic        ovf;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = '0;
    logic [1:0]  base_sel = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_clr = 1'b0;
    logic        bus_ovf_clr = 1'b0;
    logic        bus_ctl_wr = 1'b0;
    logic        ctl_irq_en = 1'b0;
    logic        ctl_tick_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic        rd_ovf;
    logic        rd_valid;
    logic        irq;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    interval_clock uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_src    (tick_src),
        .base_sel    (base_sel),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_clr     (bus_clr),
        .bus_ovf_clr (bus_ovf_clr),
        .bus_ctl_wr  (bus_ctl_wr),
        .ctl_irq_en  (ctl_irq_en),
        .ctl_tick_en (ctl_tick_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .rd_ovf      (rd_ovf),
        .rd_valid    (rd_valid),
        .irq         (irq)
    );

    // Monitor: pops the scoreboard on every read result
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected read result cnt=%0h ovf=%0b, expected none",
                         rd_data, rd_ovf);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rd_data !== e.cnt || rd_ovf !== e.ovf) begin
                    n_bad++;
                    $display("FAIL %s: read cnt=%0h ovf=%0b, expected cnt=%0h ovf=%0b",
                             e.req, rd_data, rd_ovf, e.cnt, e.ovf);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one rising edge on a source; the count settles before the task returns
    task automatic tick(input int src, input int high_cyc);
        @(negedge clk) tick_src[src] = 1'b1;
        idle(high_cyc);
        tick_src[src] = 1'b0;
        idle(3);
    endtask

    task automatic ctl(input logic ie, input logic te);  // R12
        @(negedge clk);
        bus_ctl_wr = 1'b1; ctl_irq_en = ie; ctl_tick_en = te;
        @(negedge clk) bus_ctl_wr = 1'b0;
    endtask

    // driver: queue the expected word, then run a two-cycle read
    task automatic rd_exp(input logic [11:0] c, input logic o, input string req);
        exp_t e;
        e.cnt = c; e.ovf = o; e.req = req;
        @(negedge clk);
        sb_q.push_back(e);
        bus_rd = 1'b1;
        idle(2);
        bus_rd = 1'b0;
        idle(2);
    endtask

    task automatic wr(input logic [11:0] v);
        @(negedge clk);
        bus_wr = 1'b1; wr_data = v;
        idle(2);
        bus_wr = 1'b0;
        idle(2);
    endtask

    task automatic clr_cnt();
        @(negedge clk) bus_clr = 1'b1;
        idle(2);
        bus_clr = 1'b0;
        idle(2);
    endtask

    task automatic ovf_clear();
        @(negedge clk) bus_ovf_clr = 1'b1;
        @(negedge clk) bus_ovf_clr = 1'b0;
        idle(1);
    endtask

    initial begin
        exp_t e;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk("R1 irq", int'(irq), 0);
        rd_exp(12'h000, 1'b0, "R1");

        // R5: ticks dropped while disabled
        tick(0, 2);
        rd_exp(12'h000, 1'b0, "R5 disabled");

        // R12 enables ticks; R2 counting, long high pulse counts once
        ctl(1'b0, 1'b1);
        tick(0, 2); tick(0, 2); tick(0, 2);
        rd_exp(12'h003, 1'b0, "R2 three ticks");
        tick(0, 12);
        rd_exp(12'h004, 1'b0, "R2 long pulse");

        // R3: source select
        tick(1, 2);
        rd_exp(12'h004, 1'b0, "R3 unselected");
        base_sel = 2'd1;
        tick(1, 2); tick(1, 3); tick(0, 2);
        rd_exp(12'h006, 1'b0, "R3 source one");

        // R5: stop and resume accumulate
        ctl(1'b0, 1'b0);
        tick(1, 2);
        rd_exp(12'h006, 1'b0, "R5 stopped");
        ctl(1'b0, 1'b1);
        tick(1, 2);
        rd_exp(12'h007, 1'b0, "R5 resumed");

        // R8: write then count on
        wr(12'd100);
        rd_exp(12'd100, 1'b0, "R8 write");
        tick(1, 2);

        // R6/R7: tick during a held read, re-read on the first free cycle
        @(negedge clk);
        e.cnt = 12'd101; e.ovf = 1'b0; e.req = "R6 hold";
        sb_q.push_back(e);
        bus_rd = 1'b1;
        @(negedge clk) tick_src[1] = 1'b1;
        idle(2);
        tick_src[1] = 1'b0;
        idle(3);
        bus_rd = 1'b0;
        @(negedge clk);
        e.cnt = 12'd102; e.ovf = 1'b0; e.req = "R7 catch-up";
        sb_q.push_back(e);
        bus_rd = 1'b1;
        @(negedge clk) bus_rd = 1'b0;
        idle(3);

        // R7/R8: two ticks inside one long write
        @(negedge clk);
        bus_wr = 1'b1; wr_data = 12'd200;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk) tick_src[1] = 1'b1;
            idle(2);
            tick_src[1] = 1'b0;
            idle(2);
        end
        idle(3);
        bus_wr = 1'b0;
        idle(2);
        rd_exp(12'd202, 1'b0, "R7 two pending");

        // R4/R10: wrap, interrupt, keep counting
        wr(12'hFFE);
        ctl(1'b1, 1'b1);
        tick(1, 2);
        chk("R10 no ovf", int'(irq), 0);
        rd_exp(12'hFFF, 1'b0, "R4 before wrap");
        tick(1, 2);
        chk("R10 irq on wrap", int'(irq), 1);
        rd_exp(12'h000, 1'b1, "R4 wrap");
        tick(1, 2);
        rd_exp(12'h001, 1'b1, "R4 13th bit");

        // R9: clear keeps overflow and enables
        clr_cnt();
        rd_exp(12'h000, 1'b1, "R9 clear");
        chk("R9 irq kept", int'(irq), 1);
        tick(1, 2);
        rd_exp(12'h001, 1'b1, "R9 enable kept");
        ctl(1'b0, 1'b1);
        chk("R10 irq masked", int'(irq), 0);

        // R4: carry and overflow clear in the same cycle, set wins
        wr(12'hFFF);
        @(negedge clk) tick_src[1] = 1'b1;
        @(negedge clk);
        @(negedge clk) bus_ovf_clr = 1'b1;
        @(negedge clk) begin bus_ovf_clr = 1'b0; tick_src[1] = 1'b0; end
        idle(3);
        rd_exp(12'h000, 1'b1, "R4 set beats clear");
        ovf_clear();
        rd_exp(12'h000, 1'b0, "R4 cleared");

        // R11: clear beats write, write beats read
        wr(12'h123);
        @(negedge clk);
        bus_clr = 1'b1; bus_wr = 1'b1; wr_data = 12'h055;
        idle(2);
        bus_clr = 1'b0; bus_wr = 1'b0;
        idle(2);
        rd_exp(12'h000, 1'b0, "R11 clear wins");
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; wr_data = 12'h077;
        idle(2);
        bus_wr = 1'b0; bus_rd = 1'b0;
        idle(3);
        rd_exp(12'h077, 1'b0, "R11 write wins");

        idle(4);
        chk("R6 all reads seen", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule